// File: doc/BRIEF.md
# I2C Write-Only Target with Host Status Flags

This block is an I2C target that only receives. A host processor sets it up through plain register-style inputs. With the enable input high, it watches one of two SCL/SDA pin pairs and collects a 7-bit address followed by a direction bit. When the address equals the programmed own address and the transfer is a write, it acknowledges. It then acknowledges and latches every following data byte.

Four status flags report bus activity:
- a bus-busy flag that is set by a START and cleared by a STOP;
- a sticky address-match flag that only a host write of 0 clears;
- a buffer-full flag that a host read of the byte clears;
- a word-address flag that marks the first data byte of a transfer.

An active-low interrupt follows the buffer and match flags through separate enables.

Both pins pass through a two-stage synchroniser. START and STOP are SDA edges seen while SCL is high. A flag or an acknowledge responds three clock edges after the pin change: two synchroniser stages and then the state register. The SDA outputs are open-drain enables, so a 1 means the pin is pulled low.

Top module: `i2c_flag_target`

## Requirements
- R1: While `en` is 0 the block never pulls SDA low and sets no flag. The bus still passes through the synchroniser, so enabling the block causes no false event.
- R2: With `pin_sel` = 1 the block listens on `scl_a`/`sda_a_in` and drives only `sda_a_oe`. With `pin_sel` = 0 it uses `scl_b`/`sda_b_in` and drives only `sda_b_oe`. Traffic on the other pair is ignored.
- R3: `flag_start` is set by a START (SDA falls while SCL is high) and cleared by a STOP (SDA rises while SCL is high).
- R4: Each data byte is received MSB first and appears on `rx_data` after its 8th SCL rising edge, and `flag_buf` is then set. A one-cycle `buf_rd` pulse clears `flag_buf`. If the pulse falls in the same cycle as a new byte, the flag stays set.
- R5: `flag_match` is set when the first 7 bits after START (MSB first) equal `own_addr` and the 8th bit is 0, meaning write. A `match_wr` pulse with `match_wdata` = 0 clears it. With `match_wdata` = 1 the pulse has no effect. A clear in the same cycle as a new match loses, and the flag stays set.
- R6: `flag_word` is 1 when the byte in `rx_data` is the first data byte after a matching address, and 0 for every later byte.
- R7: `irq_n` is registered. In the clock after `(flag_buf & ie_buf) | (flag_match & ie_match)` is true, it is 0; otherwise it is 1.
- R8: For a matching address and for every data byte that follows, SDA is pulled low from the SCL falling edge after the 8th bit until the SCL falling edge after the 9th bit.
- R9: A non-matching address, or a matching address with the read bit set, gets no acknowledge. The block then ignores the bus until the next START.
- R10: A repeated START (no STOP before it) restarts address reception, and `flag_start` stays 1.
- R11: Synchronous reset clears all flags and `rx_data`, sets `irq_n` to 1 and releases both SDA enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Target enable |
| pin_sel | input | 1 | 1: pair A, 0: pair B |
| own_addr | input | 7 | Programmed target address |
| ie_buf | input | 1 | Buffer interrupt enable |
| ie_match | input | 1 | Match interrupt enable |
| buf_rd | input | 1 | Host read strobe of `rx_data` |
| match_wr | input | 1 | Host write strobe to the match bit |
| match_wdata | input | 1 | Value written with `match_wr` |
| scl_a | input | 1 | SCL of pair A |
| sda_a_in | input | 1 | SDA level of pair A |
| sda_a_oe | output | 1 | Pull SDA of pair A low |
| scl_b | input | 1 | SCL of pair B |
| sda_b_in | input | 1 | SDA level of pair B |
| sda_b_oe | output | 1 | Pull SDA of pair B low |
| rx_data | output | 8 | Last received data byte |
| flag_start | output | 1 | Bus busy since START |
| flag_match | output | 1 | Address matched (sticky) |
| flag_buf | output | 1 | New byte in `rx_data` |
| flag_word | output | 1 | `rx_data` holds the word address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A host access and a bus event can land in the same cycle, and two such collisions are tested. In one, a `match_wr` clear pulse is timed to meet the 8th address bit. In the other, a `buf_rd` pulse is timed to meet the 8th bit of a data byte. In both cases the strobe is placed exactly three edges after the SCL rise is driven. The bench expects the flag to stay set, because the new event outweighs the host clear. This is judged by a directed check and by the per-cycle model, which applies the clear before the set.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_ACK  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/i2c_tgt_linemon.sv
`timescale 1ns/1ps
// Synchronises one SCL/SDA pair and derives bus events.
module i2c_tgt_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sr, sda_sr;
  logic         scl_q, sda_q, scl_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_raw;
          sda_sr <= sda_raw;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[TOP-1:0], scl_raw};
          sda_sr <= {sda_sr[TOP-1:0], sda_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s    = scl_sr[TOP];
  assign sda_s    = sda_sr[TOP];
  assign start_ev = en & scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = en & scl_s & scl_q & ~sda_q & sda_s;
  assign rise_ev  = en & scl_s & ~scl_q;
  assign fall_ev  = en & ~scl_s & scl_q;
endmodule

// File: rtl/i2c_tgt_rx.sv
`timescale 1ns/1ps
// Bit counter, address compare and acknowledge control.
module i2c_tgt_rx
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              rise_ev,
  input  logic              fall_ev,
  output logic              ack_drive,
  output logic              match_hit,
  output logic              byte_hit,
  output logic [ADDR_W:0]   byte_val,
  output logic              first_byte
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              addr_ok, ack_q, first_q, last_rise, shifting;

  assign last_rise  = rise_ev && (cnt == LAST);
  assign shifting   = (st == ST_ADDR || st == ST_DATA) && (cnt != FULL);
  assign byte_val   = {sh[BYTE_W-2:0], sda_s};
  assign match_hit  = last_rise && st == ST_ADDR && sh[ADDR_W-1:0] == own_addr && !sda_s;
  assign byte_hit   = last_rise && st == ST_DATA;
  assign ack_drive  = ack_q;
  assign first_byte = first_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      addr_ok <= 1'b0;
      ack_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (start_ev) begin
      st      <= ST_ADDR;
      cnt     <= '0;
      addr_ok <= 1'b0;
      ack_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (stop_ev) begin
      st    <= ST_IDLE;
      ack_q <= 1'b0;
    end else if (rise_ev) begin
      if (shifting) begin
        sh  <= byte_val;
        cnt <= cnt + CNT_W'(1);
      end
      if (match_hit) begin
        addr_ok <= 1'b1;
        first_q <= 1'b1;
      end
      if (byte_hit) first_q <= 1'b0;
    end else if (fall_ev) begin
      case (st)
        ST_ACK: begin
          ack_q <= 1'b0;
          st    <= ST_DATA;
          cnt   <= '0;
        end
        ST_ADDR: if (cnt == FULL) begin
          if (addr_ok) begin
            ack_q <= 1'b1;
            st    <= ST_ACK;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_DATA: if (cnt == FULL) begin
          ack_q <= 1'b1;
          st    <= ST_ACK;
        end
        default: ;
      endcase
    end
  end

  // R1
  quiet_off_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !ack_drive);
  // R8
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst) $rose(ack_drive) |-> $past(fall_ev));
endmodule

// File: rtl/i2c_tgt_flags.sv
`timescale 1ns/1ps
// Status flags, receive buffer and interrupt output.
module i2c_tgt_flags #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              match_hit,
  input  logic              byte_hit,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              first_byte,
  input  logic              buf_rd,
  input  logic              match_wr,
  input  logic              match_wdata,
  input  logic              ie_buf,
  input  logic              ie_match,
  output logic              flag_start,
  output logic              flag_match,
  output logic              flag_buf,
  output logic              flag_word,
  output logic [BYTE_W-1:0] rx_data,
  output logic              irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_start <= 1'b0;
      flag_match <= 1'b0;
      flag_buf   <= 1'b0;
      flag_word  <= 1'b0;
      rx_data    <= '0;
      irq_n      <= 1'b1;
    end else begin
      irq_n <= !((flag_buf && ie_buf) || (flag_match && ie_match));
      if (start_ev)     flag_start <= 1'b1;
      else if (stop_ev) flag_start <= 1'b0;
      if (match_hit)                      flag_match <= 1'b1;
      else if (match_wr && !match_wdata)  flag_match <= 1'b0;
      if (byte_hit) begin
        flag_buf  <= 1'b1;
        flag_word <= first_byte;
        rx_data   <= byte_val;
      end else if (buf_rd) begin
        flag_buf <= 1'b0;
      end
    end
  end

  // R3
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst) stop_ev |=> !flag_start);
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (rst) (buf_rd && !byte_hit) |=> !flag_buf);
  // R5
  one_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (match_wr && match_wdata && flag_match) |=> flag_match);
  // R5
  zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (match_wr && !match_wdata && !match_hit) |=> !flag_match);
  // R7
  irq_low_chk: assert property (@(posedge clk) disable iff (rst) (flag_buf && ie_buf) |=> !irq_n);
endmodule

// File: rtl/i2c_flag_target.sv
`timescale 1ns/1ps
// Receive-only I2C target with host status flags.
module i2c_flag_target #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pin_sel,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ie_buf,
  input  logic              ie_match,
  input  logic              buf_rd,
  input  logic              match_wr,
  input  logic              match_wdata,
  input  logic              scl_a,
  input  logic              sda_a_in,
  output logic              sda_a_oe,
  input  logic              scl_b,
  input  logic              sda_b_in,
  output logic              sda_b_oe,
  output logic [ADDR_W:0]   rx_data,
  output logic              flag_start,
  output logic              flag_match,
  output logic              flag_buf,
  output logic              flag_word,
  output logic              irq_n
);
  localparam int BYTE_W = ADDR_W + 1;

  logic scl_raw, sda_raw, sda_s;
  logic start_ev, stop_ev, rise_ev, fall_ev;
  logic ack_drive, match_hit, byte_hit, first_byte;
  logic [BYTE_W-1:0] byte_val;

  assign scl_raw = pin_sel ? scl_a : scl_b;
  assign sda_raw = pin_sel ? sda_a_in : sda_b_in;

  i2c_tgt_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .en(en), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  i2c_tgt_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst(rst), .en(en), .own_addr(own_addr), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .ack_drive(ack_drive), .match_hit(match_hit), .byte_hit(byte_hit),
    .byte_val(byte_val), .first_byte(first_byte)
  );

  i2c_tgt_flags #(.BYTE_W(BYTE_W)) u_flags (
    .clk(clk), .rst(rst), .start_ev(start_ev), .stop_ev(stop_ev),
    .match_hit(match_hit), .byte_hit(byte_hit), .byte_val(byte_val),
    .first_byte(first_byte), .buf_rd(buf_rd), .match_wr(match_wr),
    .match_wdata(match_wdata), .ie_buf(ie_buf), .ie_match(ie_match),
    .flag_start(flag_start), .flag_match(flag_match), .flag_buf(flag_buf),
    .flag_word(flag_word), .rx_data(rx_data), .irq_n(irq_n)
  );

  assign sda_a_oe = ack_drive & pin_sel;
  assign sda_b_oe = ack_drive & ~pin_sel;

  // R2
  pair_excl_chk: assert property (@(posedge clk) disable iff (rst) sda_a_oe |-> pin_sel);
endmodule

// File: tb/i2c_flag_target_test.sv
`timescale 1ns/1ps
module i2c_flag_target_test;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, pin_sel = 1'b1;
  logic [6:0] own_addr = 7'h5A;
  logic ie_buf = 1'b0, ie_match = 1'b0, buf_rd = 1'b0, match_wr = 1'b0, match_wdata = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, route = 1'b1;
  logic ma_scl, ma_sda, mb_scl, mb_sda, sda_a_line, sda_b_line;
  logic sda_a_oe, sda_b_oe, flag_start, flag_match, flag_buf, flag_word, irq_n;
  logic [7:0] rx_data;

  assign ma_scl = route ? m_scl : 1'b1;
  assign ma_sda = route ? m_sda : 1'b1;
  assign mb_scl = route ? 1'b1 : m_scl;
  assign mb_sda = route ? 1'b1 : m_sda;
  assign sda_a_line = ma_sda & ~sda_a_oe;
  assign sda_b_line = mb_sda & ~sda_b_oe;

  i2c_flag_target uut (
    .clk(clk), .rst(rst), .en(en), .pin_sel(pin_sel), .own_addr(own_addr),
    .ie_buf(ie_buf), .ie_match(ie_match), .buf_rd(buf_rd), .match_wr(match_wr),
    .match_wdata(match_wdata), .scl_a(ma_scl), .sda_a_in(sda_a_line), .sda_a_oe(sda_a_oe),
    .scl_b(mb_scl), .sda_b_in(sda_b_line), .sda_b_oe(sda_b_oe), .rx_data(rx_data),
    .flag_start(flag_start), .flag_match(flag_match), .flag_buf(flag_buf),
    .flag_word(flag_word), .irq_n(irq_n)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [3:0] hs = 4'hF, hd = 4'hF;
  int  e_st = 0, e_cnt = 0, e_sh = 0, e_rx = 0;
  bit  e_ok = 0, e_first = 0, e_ack = 0;
  bit  e_start = 0, e_match = 0, e_buf = 0, e_word = 0, e_irq = 1;

  always @(posedge clk) begin
    bit cs, ps, cd, pd, hit_m, hit_b;
    if (rst) begin
      hs = 4'hF; hd = 4'hF;
      e_st = 0; e_cnt = 0; e_sh = 0; e_rx = 0; e_ok = 0; e_first = 0; e_ack = 0;
      e_start = 0; e_match = 0; e_buf = 0; e_word = 0; e_irq = 1;
    end else begin
      e_irq = !((e_buf && ie_buf) || (e_match && ie_match));
      hs = {hs[2:0], pin_sel ? ma_scl : mb_scl};
      hd = {hd[2:0], pin_sel ? ma_sda : mb_sda};
      cs = hs[2]; ps = hs[3]; cd = hd[2]; pd = hd[3];
      hit_m = 0; hit_b = 0;
      if (!en) begin
        e_st = 0; e_ack = 0; e_cnt = 0;
      end else if (cs && ps && pd && !cd) begin
        e_st = 1; e_cnt = 0; e_ack = 0; e_first = 0; e_ok = 0; e_start = 1;
      end else if (cs && ps && !pd && cd) begin
        e_st = 0; e_ack = 0; e_start = 0;
      end else if (cs && !ps) begin
        if ((e_st == 1 || e_st == 2) && e_cnt < 8) begin
          e_sh = ((e_sh << 1) | int'(cd)) & 255;
          if (e_cnt == 7) begin
            if (e_st == 1) begin
              hit_m = ((e_sh >> 1) == int'(own_addr)) && !cd;
              if (hit_m) e_ok = 1;
            end else hit_b = 1;
          end
          e_cnt++;
        end
      end else if (!cs && ps) begin
        if (e_st == 3) begin
          e_ack = 0; e_st = 2; e_cnt = 0;
        end else if ((e_st == 1 || e_st == 2) && e_cnt == 8) begin
          if (e_st == 2 || e_ok) begin e_ack = 1; e_st = 3; end
          else e_st = 0;
        end
      end
      if (buf_rd) e_buf = 0;
      if (match_wr && !match_wdata) e_match = 0;
      if (hit_m) begin e_match = 1; e_first = 1; end
      if (hit_b) begin e_buf = 1; e_rx = e_sh; e_word = e_first; e_first = 0; end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      chk("R3 flag_start", int'(flag_start), int'(e_start));
      chk("R5 flag_match", int'(flag_match), int'(e_match));
      chk("R4 flag_buf", int'(flag_buf), int'(e_buf));
      chk("R6 flag_word", int'(flag_word), int'(e_word));
      chk("R4 rx_data", int'(rx_data), e_rx);
      chk("R7 irq_n", int'(irq_n), int'(e_irq));
      chk("R8 R2 sda_a_oe", int'(sda_a_oe), int'(e_ack && pin_sel));
      chk("R8 R2 sda_b_oe", int'(sda_b_oe), int'(e_ack && !pin_sel));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; idle(Q); m_scl = 1; idle(Q); m_sda = 0; idle(Q); m_scl = 0; idle(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; idle(Q); m_scl = 1; idle(Q); m_sda = 1; idle(Q);
  endtask

  // strobe 1: match clear, 2: buffer read, timed to meet this bit's rise
  task automatic send_bit(input logic b, input int strobe);
    m_sda = b; idle(Q); m_scl = 1;
    if (strobe != 0) begin
      idle(2);
      if (strobe == 1) begin match_wr = 1; match_wdata = 0; end
      else buf_rd = 1;
      idle(1);
      match_wr = 0; buf_rd = 0;
      idle(2*Q - 3);
    end else idle(2*Q);
    m_scl = 0; idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input int strobe, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? strobe : 0);
    m_sda = 1; idle(Q); m_scl = 1; idle(Q);
    acked = route ? !sda_a_line : !sda_b_line;
    idle(Q); m_scl = 0; idle(Q);
  endtask

  task automatic host_rd();
    buf_rd = 1; idle(1); buf_rd = 0;
  endtask

  task automatic host_mw(input logic v);
    match_wr = 1; match_wdata = v; idle(1); match_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    idle(5);
    rst = 0;
    idle(2);
    // R11 reset state
    chk("R11 flags", int'({flag_start, flag_match, flag_buf, flag_word}), 0);
    chk("R11 rx_data", int'(rx_data), 0);
    chk("R11 irq_n", int'(irq_n), 1);
    chk("R11 oe", int'({sda_a_oe, sda_b_oe}), 0);

    en = 1; pin_sel = 1; route = 1;
    bus_start();
    chk("R3 start set", int'(flag_start), 1);
    send_byte({7'h5A, 1'b0}, 0, ak); chk("R8 addr ack", int'(ak), 1);
    chk("R5 match set", int'(flag_match), 1);
    send_byte(8'h3C, 0, ak); chk("R8 data ack", int'(ak), 1);
    chk("R4 first byte", int'(rx_data), 'h3C);
    chk("R6 word flag first", int'(flag_word), 1);
    send_byte(8'hA5, 0, ak);
    chk("R6 word flag later", int'(flag_word), 0);
    bus_stop(); idle(4);
    chk("R3 stop clears", int'(flag_start), 0);
    chk("R4 second byte", int'(rx_data), 'hA5);
    chk("R4 buf set", int'(flag_buf), 1);

    host_rd(); idle(2);
    chk("R4 read clears", int'(flag_buf), 0);
    host_mw(1); idle(2);
    chk("R5 write 1 ignored", int'(flag_match), 1);
    host_mw(0); idle(2);
    chk("R5 write 0 clears", int'(flag_match), 0);

    ie_buf = 1; ie_match = 1;
    bus_start(); send_byte({7'h5A, 1'b0}, 0, ak); send_byte(8'h81, 0, ak); bus_stop(); idle(4);
    chk("R7 irq low", int'(irq_n), 0);
    host_rd(); host_mw(0); idle(3);
    chk("R7 irq high", int'(irq_n), 1);

    bus_start(); send_byte({7'h11, 1'b0}, 0, ak);
    chk("R9 mismatch nack", int'(ak), 0);
    send_byte(8'hEE, 0, ak);
    chk("R9 data ignored nack", int'(ak), 0);
    bus_stop(); idle(4);
    chk("R9 no flags", int'({flag_match, flag_buf}), 0);
    chk("R9 buffer kept", int'(rx_data), 'h81);

    bus_start(); send_byte({7'h5A, 1'b1}, 0, ak); bus_stop(); idle(4);
    chk("R9 read nack", int'(ak), 0);
    chk("R9 read no match", int'(flag_match), 0);

    bus_start(); send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
    bus_start();
    chk("R10 start kept", int'(flag_start), 1);
    send_byte({7'h5A, 1'b0}, 0, ak); chk("R10 restart ack", int'(ak), 1);
    send_byte(8'h77, 0, ak); bus_stop(); idle(4);
    chk("R10 byte after restart", int'(rx_data), 'h77);
    chk("R10 word after restart", int'(flag_word), 1);
    host_rd(); host_mw(0); idle(3);

    pin_sel = 0; route = 1; idle(2);
    bus_start(); send_byte({7'h5A, 1'b0}, 0, ak); bus_stop(); idle(4);
    chk("R2 other pair nack", int'(ak), 0);
    chk("R2 other pair no flags", int'({flag_start, flag_match, flag_buf}), 0);
    route = 0; idle(2);
    bus_start(); send_byte({7'h5A, 1'b0}, 0, ak);
    chk("R2 pair B ack", int'(ak), 1);
    send_byte(8'h42, 0, ak); bus_stop(); idle(4);
    chk("R2 pair B byte", int'(rx_data), 'h42);
    host_rd(); host_mw(0); idle(3);

    en = 0; idle(2);
    bus_start();
    chk("R1 no start flag", int'(flag_start), 0);
    send_byte({7'h5A, 1'b0}, 0, ak);
    chk("R1 no ack", int'(ak), 0);
    send_byte(8'h99, 0, ak); bus_stop(); idle(4);
    chk("R1 no flags", int'({flag_match, flag_buf}), 0);
    en = 1; idle(4);
    chk("R1 no false event", int'(flag_start), 0);

    bus_start(); send_byte({7'h5A, 1'b0}, 1, ak);
    chk("R5 set beats clear", int'(flag_match), 1);
    send_byte(8'h5E, 2, ak);
    chk("R4 set beats read", int'(flag_buf), 1);
    chk("R4 collided byte", int'(rx_data), 'h5E);
    bus_stop(); idle(6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule